// File: doc/BRIEF.md
# PWM Run Control with Prescaler

This block is a byte-wide control register wrapped around a small two-output pulse-width generator. Software writes the control byte to pick one of two clock-enable sources, a division ratio, and the run state. A second byte sets the active level of each output group. The generator is a plain up-counter that runs from zero to a programmable period and then wraps. Each output is active while the count is below that output's compare value.

A stop can take effect on the next prescaled tick, or it can be held off until the current waveform cycle has finished. A status output reports whether the counter is really advancing. During a deferred stop it stays high until the cycle boundary. Writing the run bit back to one during that window cancels the stop with no gap. Any change to the division ratio or to the clock source clears the prescaler count, so a new setting never starts with a partial division period.

Top module: `pwm_run_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read back 0, `running` is 0, and `out_a` and `out_b` are 1, which is the inactive level for polarity 0.
- R2: The control byte at address 0 has this layout: bits 7:6 are the division select, bit 5 is the clock source, bit 1 is the full-cycle flag and bit 0 is the run bit. Bits 4:2 always read 0. Writing 0xFF reads back as 0xE3. Read data appears one clock after the address is presented.
- R3: The division select sets the ratio of source enables per counter tick: 00 gives 1, 01 gives 4, 10 gives 32 and 11 gives 256.
- R4: A clock-source bit of 1 takes ticks from `fast_en`. A clock-source bit of 0 takes them from `slow_en`.
- R5: When the run bit is 1 and the generator is idle, the counter starts at 0. On each tick it counts 0..`period` and then wraps. An output is active while the count is below its compare input.
- R6: At address 1, bit 0 sets the polarity of group A and bit 1 sets the polarity of group B. A 1 makes the output active high and a 0 makes it active low.
- R7: With the full-cycle flag at 0, clearing the run bit halts the counter on the next tick. One clock later both outputs go to their inactive level.
- R8: With the full-cycle flag at 1, clearing the run bit halts the counter only on the tick that ends the cycle, where the count equals `period`.
- R9: Writing the run bit to 1 while a deferred stop is pending cancels the stop, and the generator keeps running.
- R10: A change of the division select or of the clock source clears the prescaler count. The next tick then comes a full new ratio after the clear.
- R11: `running` is high exactly while the counter is advancing, including the window of a deferred stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_en | input | 1 | Fast clock-enable source |
| slow_en | input | 1 | Slow clock-enable source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects polarity |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| period | input | CNT_W | Last count value of a waveform cycle |
| cmp_a | input | CNT_W | Compare value for group A |
| cmp_b | input | CNT_W | Compare value for group B |
| out_a | output | 1 | Group A output |
| out_b | output | 1 | Group B output |
| running | output | 1 | Generator is advancing |

## Verification
A wrong prescaler count or a wrong source choice stretches or shrinks every output phase. This shows in the duty count that the bench takes over two whole periods, as early as the first measured window. A stop decision taken at the wrong tick moves the falling edge of `running` by one or more clocks, and the bench counts the clocks between the stop write and that edge exactly. A prescaler that keeps its count after a ratio change delays or advances the stop that follows, in this case by several clocks.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int REG_W = 8;
  localparam int PRE_W = 8;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_POL  = 1'b1;

  typedef struct packed {
    logic [1:0] div_sel;
    logic       src_fast;
    logic [2:0] zero;
    logic       full_cyc;
    logic       run;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'b00:   div_last = PRE_W'(0);
      2'b01:   div_last = PRE_W'(3);
      2'b10:   div_last = PRE_W'(31);
      default: div_last = PRE_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [1:0]       div_sel,
  output logic             src_fast,
  output logic             full_cyc,
  output logic             run,
  output logic             pol_a,
  output logic             pol_b
);
  ctrl_t      ctrl_q;
  logic [1:0] pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pol_q  <= '0;
      rdata  <= '0;
    end else begin
      if (we && addr == ADDR_CTRL) begin
        ctrl_q      <= ctrl_t'(wdata);
        ctrl_q.zero <= '0;
      end
      if (we && addr == ADDR_POL) pol_q <= wdata[1:0];
      rdata <= (addr == ADDR_POL) ? {{(REG_W-2){1'b0}}, pol_q} : REG_W'(ctrl_q);
    end
  end

  assign div_sel  = ctrl_q.div_sel;
  assign src_fast = ctrl_q.src_fast;
  assign full_cyc = ctrl_q.full_cyc;
  assign run      = ctrl_q.run;
  assign pol_a    = pol_q[0];
  assign pol_b    = pol_q[1];

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_CTRL) |-> (rdata[4:2] == 3'b000));
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fast_en,
  input  logic       slow_en,
  input  logic [1:0] div_sel,
  input  logic       src_fast,
  input  logic       hold,
  output logic       tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [2:0]       sel_q;
  logic             src_en, chg, clr;
  logic [PRE_W-1:0] last;

  assign src_en = src_fast ? fast_en : slow_en;
  assign chg    = {div_sel, src_fast} != sel_q;
  assign clr    = chg || hold;
  assign last   = div_last(div_sel);
  assign tick   = src_en && !clr && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= {div_sel, src_fast};
      if (clr)         cnt_q <= '0;
      else if (src_en) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end
  end

  // R10
  sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    chg |=> (cnt_q == '0));
  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_req,
  input  logic             full_cyc,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             pol_a,
  input  logic             pol_b,
  output logic             run_q,
  output logic             out_a,
  output logic             out_b
);
  logic [CNT_W-1:0] cnt_q;
  logic             end_cyc, act_a, act_b;

  assign end_cyc = cnt_q >= period;
  assign act_a   = run_q && (cnt_q < cmp_a);
  assign act_b   = run_q && (cnt_q < cmp_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      out_a <= 1'b1;
      out_b <= 1'b1;
    end else begin
      if (!run_q) begin
        if (run_req) begin
          run_q <= 1'b1;
          cnt_q <= '0;
        end
      end else if (tick) begin
        if (!run_req && (!full_cyc || end_cyc)) begin
          run_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= end_cyc ? '0 : cnt_q + 1'b1;
        end
      end
      out_a <= pol_a ? act_a : !act_a;
      out_b <= pol_b ? act_b : !act_b;
    end
  end

  // R5
  start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (cnt_q == '0));
  // R7
  stop_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(tick));
  // R8
  stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(run_q) && $past(full_cyc)) |-> $past(end_cyc));
  // R9
  keep_running_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && run_req) |=> run_q);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (out_a != $past(pol_a)) && (out_b != $past(pol_b)));
endmodule

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl
  import pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_en,
  input  logic             slow_en,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic             out_a,
  output logic             out_b,
  output logic             running
);
  logic [1:0] div_sel;
  logic       src_fast, full_cyc, run, pol_a, pol_b, tick;

  pwm_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .div_sel(div_sel), .src_fast(src_fast),
    .full_cyc(full_cyc), .run(run), .pol_a(pol_a), .pol_b(pol_b)
  );

  pwm_prescale u_pre (
    .clk(clk), .rst(rst), .fast_en(fast_en), .slow_en(slow_en),
    .div_sel(div_sel), .src_fast(src_fast), .hold(!running), .tick(tick)
  );

  pwm_wavegen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst(rst), .tick(tick), .run_req(run), .full_cyc(full_cyc),
    .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b), .pol_a(pol_a),
    .pol_b(pol_b), .run_q(running), .out_a(out_a), .out_b(out_b)
  );

  // R11
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !running |-> !tick);
endmodule

// File: tb/sim_pwm_run_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_run_ctrl;
  logic       clk = 1'b0, rst = 1'b1;
  logic       fast_en = 1'b1, slow_en = 1'b0;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] period = 8'd9, cmp_a = 8'd5, cmp_b = 8'd1;
  logic       out_a, out_b, running;

  int vecs = 0, miss = 0;

  always #5 clk = ~clk;

  pwm_run_ctrl u0 (
    .clk(clk), .rst(rst), .fast_en(fast_en), .slow_en(slow_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .out_a(out_a), .out_b(out_b), .running(running)
  );

  initial forever begin
    @(negedge clk);
    slow_en = ~slow_en;
  end

  typedef struct packed {
    logic [1:0] psel;
    logic       src;
    logic       pol;
    logic [7:0] per;
    logic [7:0] cmp;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{2'd0, 1'b1, 1'b1, 8'd3, 8'd2},
    '{2'd1, 1'b1, 1'b0, 8'd4, 8'd1},
    '{2'd2, 1'b1, 1'b1, 8'd2, 8'd3},
    '{2'd3, 1'b1, 1'b1, 8'd1, 8'd1},
    '{2'd0, 1'b0, 1'b0, 8'd5, 8'd0},
    '{2'd1, 1'b0, 1'b1, 8'd3, 8'd2}
  };

  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 32;
      default: return 256;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // clocks with running high after the write edge, then output level one clock later
  task automatic count_run(output int n);
    n = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (running) n++;
      else break;
    end
  endtask

  initial begin
    #2_000_000;
    vecs++; miss++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, win, ra, sd, ca, cb, expa, expb;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(1'b0, d); check("R1 ctrl", d, 0);
    rd(1'b1, d); check("R1 pol", d, 0);
    check("R1 running", running, 0);
    check("R1 outs", {out_a, out_b}, 3);

    // R2 reserved bits read zero
    wr(1'b0, 8'hFF);
    rd(1'b0, d); check("R2 readback", d, 8'hE3);
    wr(1'b0, 8'h00);
    repeat (600) @(posedge clk);
    @(negedge clk); check("R7 halted after 0xFF", running, 0);

    // R3 R4 R5 R6 table walk
    foreach (VT[i]) begin
      wr(1'b0, 8'h00);
      repeat (600) @(posedge clk);
      period = VT[i].per; cmp_a = VT[i].cmp; cmp_b = 8'd1;
      wr(1'b1, {6'b0, VT[i].pol, VT[i].pol});
      wr(1'b0, {VT[i].psel, VT[i].src, 3'b000, 1'b0, 1'b1});
      repeat (8) @(posedge clk);
      ra = ratio(VT[i].psel);
      sd = VT[i].src ? 1 : 2;
      win = 2 * (VT[i].per + 1) * ra * sd;
      expa = 2 * ((VT[i].cmp < VT[i].per + 1) ? VT[i].cmp : VT[i].per + 1) * ra * sd;
      expb = 2 * ra * sd;
      ca = 0; cb = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        if (out_a == VT[i].pol) ca++;
        if (out_b == VT[i].pol) cb++;
      end
      check("R3 R4 R5 R6 group A active clocks", ca, expa);
      check("R3 R4 R5 R6 group B active clocks", cb, expb);
    end

    wr(1'b0, 8'h00);
    repeat (600) @(posedge clk);
    period = 8'd9; cmp_a = 8'd5; cmp_b = 8'd1;
    wr(1'b1, 8'h03);

    // R7 immediate stop: one clock of running after the write
    wr(1'b0, 8'h21);
    repeat (5) @(posedge clk);
    wr(1'b0, 8'h20);
    count_run(n); check("R7 immediate stop clocks", n, 1);
    @(negedge clk); check("R7 inactive level", {out_a, out_b}, 0);

    // R8 R11 deferred stop: started cnt 3, ends when count 9 wraps
    wr(1'b0, 8'h23);
    repeat (3) @(posedge clk);
    wr(1'b0, 8'h22);
    count_run(n); check("R8 R11 deferred stop clocks", n, 7);
    @(negedge clk); check("R8 inactive level", {out_a, out_b}, 0);

    // R9 cancel pending stop
    wr(1'b0, 8'h23);
    repeat (3) @(posedge clk);
    wr(1'b0, 8'h22);
    @(posedge clk);
    wr(1'b0, 8'h23);
    count_run(n); check("R9 keeps running", n, 64);
    wr(1'b0, 8'h20);
    repeat (4) @(posedge clk);

    // R10 ratio change clears prescaler: 256 -> 4 with immediate stop
    wr(1'b0, 8'hE1);
    repeat (100) @(posedge clk);
    wr(1'b0, 8'h60);
    count_run(n); check("R10 stop after cleared prescaler", n, 5);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule